// File: doc/BRIEF.md
# Page Table Walker for TLB Refill

When the translation buffer misses, this block fetches the missing translation from a page table in physical memory. The page table is a flat array of 32-bit entries in physical memory, indexed by virtual page number. A base register input gives its starting address. The walker accepts one miss at a time. It computes the entry address, issues a single read on a valid/ready request channel and waits for the response word.

If the entry is marked present, the walker gives the translation buffer one refill pulse. The pulse carries the virtual page number, the physical page number and the entry's status flags, and the stalled access can then retry. If the entry is not present, the walker gives one fault pulse instead, together with the full virtual address that missed, for the fault handler. The block only reads memory. The low 12 address bits are the page offset and are never translated.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_req_valid, refill_valid and fault are all 0.
- R2: The read address is ptbase plus four times the virtual page number, where the page number is req_vaddr[31:12], modulo 2^32. The offset bits req_vaddr[11:0] do not affect the address.
- R3: Once mem_req_valid is raised, it stays high with an unchanged mem_req_addr until a cycle in which mem_req_ready is 1. It then drops in the next cycle, and exactly one read is issued per accepted request.
- R4: req_ready is 0 from the cycle after a request is accepted through the cycle of the result pulse. A req_valid held high during that time starts no second walk.
- R5: When entry bit 0 (present) is 1, refill_valid pulses for one cycle in the cycle after the response is taken. During the pulse, refill_ppn equals entry bits 31:12 and refill_vpn equals the missed page number.
- R6: During a refill, refill_ref, refill_dirty, refill_wr and refill_sup equal entry bits 1, 2, 3 and 4.
- R7: When entry bit 0 is 0, fault pulses for one cycle instead of refill_valid, and fault_vaddr equals the full 32-bit virtual address of the request.
- R8: Each request produces exactly one of refill_valid or fault, never both, each lasting one cycle.
- R9: A mem_rsp_valid arriving while no read is outstanding is ignored: it produces no refill or fault, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_ready | output | 1 | Walker idle, can accept a miss |
| req_vaddr | input | 32 | Virtual address that missed |
| ptbase | input | 32 | Physical base address of the page table |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry returned |
| refill_valid | output | 1 | One-cycle refill strobe |
| refill_vpn | output | 20 | Virtual page number being refilled |
| refill_ppn | output | 20 | Physical page number from the entry |
| refill_ref | output | 1 | Referenced flag |
| refill_dirty | output | 1 | Dirty flag |
| refill_wr | output | 1 | Writable flag |
| refill_sup | output | 1 | Supervisor-only flag |
| fault | output | 1 | One-cycle page fault strobe |
| fault_vaddr | output | 32 | Faulting virtual address |

## Verification
If the walk state were corrupted, the effect would reach the ports within one cycle. The read request could be dropped or repeated, req_ready could open while a read is still outstanding, or refill and fault could both fire or neither fire. If the latched address or entry were wrong, the result pulse would carry wrong fields in the cycle right after the response. The directed scenarios therefore compare the request address at issue time and every result field in the exact pulse cycle. They also check that the pulse does not repeat in the following cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_ISSUE = 2'd1,
      W_WAIT  = 2'd2,
      W_DONE  = 2'd3
   } walk_state_t;

   typedef struct packed {
      logic sup;
      logic wr;
      logic dirty;
      logic refd;
      logic present;
   } pte_flags_t;

   localparam int FLAG_PRESENT = 0;
   localparam int FLAG_REF     = 1;
   localparam int FLAG_DIRTY   = 2;
   localparam int FLAG_WR      = 3;
   localparam int FLAG_SUP     = 4;
   localparam int FLAG_COUNT   = 5;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int PA_W      = 32,
   parameter int VPN_W     = 20,
   parameter int PTE_BYTES = 4
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [PA_W-1:0]  base,
   output logic [PA_W-1:0]  entry_addr
);
   localparam int SCALE_SH = $clog2(PTE_BYTES);
   localparam bit POW2     = ((1 << SCALE_SH) == PTE_BYTES);

   logic [PA_W-1:0] idx;
   logic [PA_W-1:0] offs;

   assign idx = PA_W'(vpn);

   generate
      if (POW2) begin : g_shift
         assign offs = idx << SCALE_SH;
      end else begin : g_mult
         assign offs = idx * PA_W'(PTE_BYTES);
      end
   endgenerate

   assign entry_addr = base + offs;
endmodule

// File: rtl/pte_decode.sv
module pte_decode
   import pt_walker_pkg::*;
#(
   parameter int PTE_W     = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic [PTE_W-1:0]           pte,
   output pte_flags_t                 flags,
   output logic [PTE_W-PAGE_BITS-1:0] ppn
);
   logic unused_rsvd;

   assign flags.present = pte[FLAG_PRESENT];
   assign flags.refd    = pte[FLAG_REF];
   assign flags.dirty   = pte[FLAG_DIRTY];
   assign flags.wr      = pte[FLAG_WR];
   assign flags.sup     = pte[FLAG_SUP];
   assign ppn           = pte[PTE_W-1:PAGE_BITS];

   generate
      if (PAGE_BITS > FLAG_COUNT) begin : g_rsvd
         assign unused_rsvd = ^pte[PAGE_BITS-1:FLAG_COUNT];
      end else begin : g_norsvd
         assign unused_rsvd = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walker_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        mem_req_ready,
   input  logic        mem_rsp_valid,
   output walk_state_t state,
   output logic        accept,
   output logic        take_rsp
);
   walk_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         W_IDLE:  if (req_valid)     nxt = W_ISSUE;
         W_ISSUE: if (mem_req_ready) nxt = W_WAIT;
         W_WAIT:  if (mem_rsp_valid) nxt = W_DONE;
         W_DONE:                     nxt = W_IDLE;
         default:                    nxt = W_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= W_IDLE;
      else        state <= nxt;
   end

   assign accept   = (state == W_IDLE) && req_valid;
   assign take_rsp = (state == W_WAIT) && mem_rsp_valid;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int PAGE_BITS = 12,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PPN_W    = PTE_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PA_W-1:0]  ptbase,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             refill_valid,
   output logic [VPN_W-1:0] refill_vpn,
   output logic [PPN_W-1:0] refill_ppn,
   output logic             refill_ref,
   output logic             refill_dirty,
   output logic             refill_wr,
   output logic             refill_sup,
   output logic             fault,
   output logic [VA_W-1:0]  fault_vaddr
);
   localparam int PTE_BYTES = PTE_W / 8;

   generate
      if (PAGE_BITS <= FLAG_COUNT || PAGE_BITS >= VA_W) begin : g_bad_page
         $error("PAGE_BITS must leave room for the flags and a page number");
      end
      if (PTE_W % 8 != 0 || PTE_W <= PAGE_BITS) begin : g_bad_pte
         $error("PTE_W must be whole bytes and wider than the offset");
      end
      if (PA_W < VPN_W) begin : g_bad_pa
         $error("PA_W too narrow for the page index");
      end
   endgenerate

   walk_state_t     state;
   logic            accept;
   logic            take_rsp;
   logic [PA_W-1:0] addr_calc;
   logic [PA_W-1:0] addr_q;
   logic [VA_W-1:0] vaddr_q;
   pte_flags_t      flags_d, flags_q;
   logic [PPN_W-1:0] ppn_d, ppn_q;

   pt_walk_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .state         (state),
      .accept        (accept),
      .take_rsp      (take_rsp)
   );

   pt_addr_gen #(
      .PA_W      (PA_W),
      .VPN_W     (VPN_W),
      .PTE_BYTES (PTE_BYTES)
   ) u_addr (
      .vpn        (req_vaddr[VA_W-1:PAGE_BITS]),
      .base       (ptbase),
      .entry_addr (addr_calc)
   );

   pte_decode #(
      .PTE_W     (PTE_W),
      .PAGE_BITS (PAGE_BITS)
   ) u_dec (
      .pte   (mem_rsp_data),
      .flags (flags_d),
      .ppn   (ppn_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         vaddr_q <= '0;
      end else if (accept) begin
         addr_q  <= addr_calc;
         vaddr_q <= req_vaddr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         ppn_q   <= '0;
      end else if (take_rsp) begin
         flags_q <= flags_d;
         ppn_q   <= ppn_d;
      end
   end

   assign req_ready     = (state == W_IDLE);
   assign mem_req_valid = (state == W_ISSUE);
   assign mem_req_addr  = addr_q;

   assign refill_valid = (state == W_DONE) &&  flags_q.present;
   assign fault        = (state == W_DONE) && !flags_q.present;
   assign refill_vpn   = vaddr_q[VA_W-1:PAGE_BITS];
   assign refill_ppn   = ppn_q;
   assign refill_ref   = flags_q.refd;
   assign refill_dirty = flags_q.dirty;
   assign refill_wr    = flags_q.wr;
   assign refill_sup   = flags_q.sup;
   assign fault_vaddr  = vaddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            refill_valid,
   input logic            fault
);
   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R3
   mem_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R4
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || refill_valid || fault) |-> !req_ready);

   // R8
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(refill_valid && fault));

   // R8
   result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid || fault) |=> !(refill_valid || fault));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .refill_valid  (refill_valid),
   .fault         (fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] ptbase = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        refill_valid;
   logic [19:0] refill_vpn;
   logic [19:0] refill_ppn;
   logic        refill_ref, refill_dirty, refill_wr, refill_sup;
   logic        fault;
   logic [31:0] fault_vaddr;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pt_walker u_pt_walker (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .ptbase        (ptbase),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .refill_valid  (refill_valid),
      .refill_vpn    (refill_vpn),
      .refill_ppn    (refill_ppn),
      .refill_ref    (refill_ref),
      .refill_dirty  (refill_dirty),
      .refill_wr     (refill_wr),
      .refill_sup    (refill_sup),
      .fault         (fault),
      .fault_vaddr   (fault_vaddr)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   // One complete walk; checks its own results.
   task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                           input logic [31:0] pte, input int rdly,
                           input int sdly, input bit hold_req);
      logic [31:0] exp_addr;
      exp_addr = base + {10'b0, va[31:12], 2'b00};
      @(negedge clk);
      check("R4", "ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_vaddr = va; ptbase = base;
      @(negedge clk);
      req_valid = hold_req;
      req_vaddr = va ^ 32'h0F0F_F000;
      check("R3", "read issued", 64'(mem_req_valid), 64'd1);
      check("R2", "entry address", 64'(mem_req_addr), 64'(exp_addr));
      check("R4", "ready while issuing", 64'(req_ready), 64'd0);
      for (int i = 0; i < rdly; i++) begin
         @(negedge clk);
         check("R3", "valid held", 64'(mem_req_valid), 64'd1);
         check("R3", "address held", 64'(mem_req_addr), 64'(exp_addr));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check("R3", "valid dropped", 64'(mem_req_valid), 64'd0);
      for (int i = 0; i < sdly; i++) begin
         @(negedge clk);
         check("R8", "no early result", 64'({refill_valid, fault}), 64'd0);
         check("R4", "ready while waiting", 64'(req_ready), 64'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      req_valid = 1'b0;
      check("R4", "ready during result", 64'(req_ready), 64'd0);
      if (pte[0]) begin
         check("R5", "refill pulse", 64'({refill_valid, fault}), 64'b10);
         check("R5", "ppn", 64'(refill_ppn), 64'(pte[31:12]));
         check("R5", "vpn", 64'(refill_vpn), 64'(va[31:12]));
         check("R6", "flags", 64'({refill_sup, refill_wr, refill_dirty, refill_ref}),
               64'(pte[4:1]));
      end else begin
         check("R7", "fault pulse", 64'({refill_valid, fault}), 64'b01);
         check("R7", "fault vaddr", 64'(fault_vaddr), 64'(va));
      end
      @(negedge clk);
      check("R8", "single-cycle result", 64'({refill_valid, fault}), 64'd0);
      check("R4", "ready again", 64'(req_ready), 64'd1);
      check("R4", "no second walk", 64'(mem_req_valid), 64'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "req_ready", 64'(req_ready), 64'd1);
      check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
      check("R1", "results", 64'({refill_valid, fault}), 64'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_stray_rsp();
      @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'h7777_701F;
      repeat (2) begin
         @(negedge clk);
         check("R9", "stray response no result", 64'({refill_valid, fault}), 64'd0);
         check("R9", "still ready", 64'(req_ready), 64'd1);
         check("R9", "no read", 64'(mem_req_valid), 64'd0);
      end
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
   endtask

   initial begin
      t_reset();
      // R5: present, referenced only
      run_walk(32'h0040_3ABC, 32'h1000_0000, 32'hABCD_E003, 0, 0, 1'b0);
      // R6: all flags set, slow memory
      run_walk(32'h1234_5678, 32'h0008_0000, 32'h1234_501F, 3, 2, 1'b0);
      // R6: only dirty and supervisor
      run_walk(32'h8000_1FFF, 32'h2000_0000, 32'h0000_1015, 1, 0, 1'b0);
      // R7: not present
      run_walk(32'hDEAD_BEEF, 32'h0001_0000, 32'hFFFF_F01E, 0, 1, 1'b0);
      // R2: base near top wraps
      run_walk(32'h0000_5000, 32'hFFFF_FFF0, 32'h0000_2003, 0, 0, 1'b0);
      // R2: offset bits ignored
      run_walk(32'h0000_5FFF, 32'hFFFF_FFF0, 32'h0000_2003, 0, 0, 1'b0);
      // R4: request held high while busy
      run_walk(32'hCAFE_0123, 32'h4000_0000, 32'h5555_5009, 2, 3, 1'b1);
      t_stray_rsp();
      // R7 then R5 back to back
      run_walk(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 0, 0, 1'b0);
      run_walk(32'hFFFF_FFFF, 32'h0000_0100, 32'hFFFF_FFFF, 0, 0, 1'b0);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule